// File: doc/BRIEF.md
# RV32 Load/Store Unit

This block executes the RV32 integer loads and stores over a simple pipelined data bus. The issuing stage presents an operation code (`funct3`), a store flag, a base operand, a signed displacement, store data and a destination register index. The unit adds the base and the displacement to form the effective address. For a store it steers the data onto the correct byte lanes and raises the matching byte write strobes. For a load it records how the returned word must be cut, and then extracts the addressed byte, halfword or word and extends it to 32 bits.

Several requests may be in flight at once. The unit registers each accepted request onto the bus and holds it there while the bus reports a stall. It keeps a tag for every outstanding request in a small first-in first-out queue. Acknowledges are matched to those tags in issue order, so any memory latency is tolerated as long as the memory answers in order. Each completion appears one cycle after its acknowledge, with a valid pulse and the destination index. A load also raises a register write enable. The `busy` output tells the issuer when no further request can be taken.

Top module: `lsu_top`

## Requirements
- R1: The bus address of a request is base + sign-extended displacement, with its two low bits forced to zero. The two low bits of the sum are the byte offset.
- R2: A byte load (funct3 000 signed, 100 unsigned) returns bits [8*offset+7 : 8*offset] of the read word, little-endian. Code 000 sign-extends the byte and code 100 zero-extends it.
- R3: A halfword load at offset 0 or 2 (funct3 001 signed, 101 unsigned) returns bits [8*offset+15 : 8*offset]. Code 001 sign-extends the halfword and code 101 zero-extends it.
- R4: A word load (funct3 010) returns the read word unchanged.
- R5: A byte store (funct3 000) raises strobe bit `offset` only and repeats the low 8 bits of the store data on all four lanes. A halfword store (001) raises strobes 0b0011 or 0b1100 and repeats the low 16 bits on both halves. A word store (010) raises 0b1111 with the data unchanged. A load raises no strobe.
- R6: A request is taken only in a cycle with `en_i` high and `busy_o` low. `busy_o` is high while the request on the bus is stalled, and while MAX_OUT requests are outstanding. A request counts as outstanding from its acceptance until its acknowledge.
- R7: Completions come out one per acknowledge, in issue order, one cycle after the acknowledge. Each carries the destination index given with its request, and no other cycle has `valid_o` high.
- R8: A load completion raises `we_o` together with `valid_o`. A store completion raises `valid_o` with `we_o` low and `result_o` zero.
- R9: While `bus_stall_i` is high, a request on the bus keeps its enable, address, strobes and data unchanged.
- R10: After reset `valid_o`, `we_o`, `busy_o` and `bus_en_o` are low.
- R11: Results are correct with a memory latency of one cycle and of two cycles, with or without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Request present |
| store_i | input | 1 | 1 = store, 0 = load |
| funct3_i | input | 3 | Width/extension code |
| base_i | input | 32 | Base operand |
| sdata_i | input | 32 | Store data |
| disp_i | input | DISP_W | Signed displacement |
| rd_i | input | 5 | Destination register index |
| busy_o | output | 1 | Unit cannot take a request this cycle |
| valid_o | output | 1 | Completion present |
| we_o | output | 1 | Register write enable (loads) |
| rd_o | output | 5 | Destination index of completion |
| result_o | output | 32 | Extended load result |
| bus_en_o | output | 1 | Bus request present |
| bus_we_o | output | 4 | Byte write strobes |
| bus_adr_o | output | 32 | Word-aligned byte address |
| bus_wdat_o | output | 32 | Write data |
| bus_rdat_i | input | 32 | Read data, valid with ack |
| bus_stall_i | input | 1 | Bus cannot take the request |
| bus_ack_i | input | 1 | One outstanding request completes |

## Verification
The properties assume that the memory raises exactly one acknowledge for each request it took, in the order it took them, and never acknowledges when nothing is outstanding. They also assume that the stall input changes only at clock edges. The bench memory model meets these conditions: it takes a request only when it is not stalling, and it returns the acknowledge through a one- or two-stage delay line. Its stall comes from a register fed by an LFSR. The issuer presents only naturally aligned halfword and word addresses, because misaligned accesses are outside the scope of the unit.

// File: rtl/lsu_pkg.sv
// Shared encodings and the per-request tag type of the load/store unit.
// Assumes RV32: 32-bit data, four byte lanes, 5-bit register index.
package lsu_pkg;
    localparam int unsigned XLEN  = 32;
    localparam int unsigned LANES = XLEN / 8;
    localparam int unsigned RD_W  = 5;

    localparam logic [2:0] F3_B  = 3'b000;
    localparam logic [2:0] F3_H  = 3'b001;
    localparam logic [2:0] F3_W  = 3'b010;
    localparam logic [2:0] F3_BU = 3'b100;
    localparam logic [2:0] F3_HU = 3'b101;

    typedef struct packed {
        logic            st;
        logic [2:0]      f3;
        logic [1:0]      off;
        logic [RD_W-1:0] rd;
    } lsu_tag_t;
endpackage

// File: rtl/lsu_store_fmt.sv
// Store lane steering: builds byte strobes and replicated write data.
// Assumes halfword offsets are even; the offset's low bit is ignored for halfwords.
module lsu_store_fmt
    import lsu_pkg::*;
(
    input  logic [2:0]       f3,
    input  logic [1:0]       off,
    input  logic [XLEN-1:0]  data,
    output logic [LANES-1:0] strb,
    output logic [XLEN-1:0]  wdat
);
    // Select strobe pattern and lane replication from the width code.
    always_comb begin
        case (f3)
            F3_B: begin
                strb = LANES'(1) << off;
                wdat = {LANES{data[7:0]}};
            end
            F3_H: begin
                strb = LANES'(3) << {off[1], 1'b0};
                wdat = {(LANES/2){data[15:0]}};
            end
            default: begin
                strb = '1;
                wdat = data;
            end
        endcase
    end
endmodule

// File: rtl/lsu_load_fmt.sv
// Load alignment: cuts the addressed byte/halfword out of a read word and
// sign- or zero-extends it. Assumes little-endian lanes and aligned halfwords.
module lsu_load_fmt
    import lsu_pkg::*;
(
    input  logic [2:0]      f3,
    input  logic [1:0]      off,
    input  logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0] shifted;

    // Bring the addressed lane down to bit 0.
    assign shifted = rdata >> {off, 3'b000};

    // Extend according to the width code.
    always_comb begin
        case (f3)
            F3_B:    res = {{(XLEN-8){shifted[7]}}, shifted[7:0]};
            F3_BU:   res = {{(XLEN-8){1'b0}}, shifted[7:0]};
            F3_H:    res = {{(XLEN-16){shifted[15]}}, shifted[15:0]};
            F3_HU:   res = {{(XLEN-16){1'b0}}, shifted[15:0]};
            default: res = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_tag_fifo.sv
// Small synchronous FIFO holding one tag per outstanding request.
// Assumes the user never pushes when full nor pops when empty.
module lsu_tag_fifo #(
    parameter int unsigned W     = 11,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store_q [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;

    // Write the incoming tag at the write pointer.
    always_ff @(posedge clk) begin
        if (push) store_q[wptr_q] <= din;
    end

    // Advance pointers with wrap and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
            if (pop)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout = store_q[rptr_q];
    assign full = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/lsu_top.sv
// RV32 load/store unit. Accepts one request per cycle when not busy, registers it
// onto a pipelined bus (held while stalled), queues a tag per request and turns each
// in-order acknowledge into a registered completion. Assumes in-order memory responses.
module lsu_top
    import lsu_pkg::*;
#(
    parameter int unsigned DISP_W  = 12,
    parameter int unsigned MAX_OUT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              store_i,
    input  logic [2:0]        funct3_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [XLEN-1:0]   sdata_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [RD_W-1:0]   rd_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic              we_o,
    output logic [RD_W-1:0]   rd_o,
    output logic [XLEN-1:0]   result_o,
    output logic              bus_en_o,
    output logic [LANES-1:0]  bus_we_o,
    output logic [XLEN-1:0]   bus_adr_o,
    output logic [XLEN-1:0]   bus_wdat_o,
    input  logic [XLEN-1:0]   bus_rdat_i,
    input  logic              bus_stall_i,
    input  logic              bus_ack_i
);
    localparam int unsigned TAG_W = $bits(lsu_tag_t);

    logic [XLEN-1:0]  eff_adr;
    logic [LANES-1:0] st_strb;
    logic [XLEN-1:0]  st_wdat;
    logic [XLEN-1:0]  ld_res;
    logic             accept;
    logic             tags_full;
    lsu_tag_t         new_tag, head_tag;
    logic [TAG_W-1:0] head_raw;

    // Effective address from base and sign-extended displacement.
    assign eff_adr = base_i + {{(XLEN-DISP_W){disp_i[DISP_W-1]}}, disp_i};

    lsu_store_fmt u_sfmt (
        .f3   (funct3_i),
        .off  (eff_adr[1:0]),
        .data (sdata_i),
        .strb (st_strb),
        .wdat (st_wdat)
    );

    // Flow control: hold off while the bus request is stuck or the tag queue is full.
    assign busy_o = (bus_en_o & bus_stall_i) | tags_full;
    assign accept = en_i & ~busy_o;

    assign new_tag = '{st: store_i, f3: funct3_i, off: eff_adr[1:0], rd: rd_i};

    lsu_tag_fifo #(.W(TAG_W), .DEPTH(MAX_OUT)) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .din   (new_tag),
        .pop   (bus_ack_i),
        .dout  (head_raw),
        .full  (tags_full)
    );
    assign head_tag = lsu_tag_t'(head_raw);

    // Bus request register: load on accept, hold while stalled, drop when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_en_o   <= 1'b0;
            bus_we_o   <= '0;
            bus_adr_o  <= '0;
            bus_wdat_o <= '0;
        end else if (accept) begin
            bus_en_o   <= 1'b1;
            bus_we_o   <= store_i ? st_strb : '0;
            bus_adr_o  <= {eff_adr[XLEN-1:2], 2'b00};
            bus_wdat_o <= st_wdat;
        end else if (bus_en_o && !bus_stall_i) begin
            bus_en_o   <= 1'b0;
        end
    end

    lsu_load_fmt u_lfmt (
        .f3    (head_tag.f3),
        .off   (head_tag.off),
        .rdata (bus_rdat_i),
        .res   (ld_res)
    );

    // Completion register: one result per acknowledge, tagged from the queue head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            we_o     <= 1'b0;
            rd_o     <= '0;
            result_o <= '0;
        end else begin
            valid_o <= bus_ack_i;
            we_o    <= bus_ack_i & ~head_tag.st;
            if (bus_ack_i) begin
                rd_o     <= head_tag.rd;
                result_o <= head_tag.st ? '0 : ld_res;
            end
        end
    end
endmodule

// File: rtl/lsu_top_chk.sv
// Property checker for lsu_top, attached by bind. Tracks outstanding requests
// with its own counter. Assumes acknowledges only for outstanding requests.
module lsu_top_chk #(
    parameter int unsigned MAX_OUT = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        en_i,
    input logic        busy_o,
    input logic        valid_o,
    input logic        we_o,
    input logic        bus_en_o,
    input logic [3:0]  bus_we_o,
    input logic [31:0] bus_adr_o,
    input logic [31:0] bus_wdat_o,
    input logic        bus_stall_i,
    input logic        bus_ack_i
);
    int outst;

    // Count accepted requests not yet acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) outst <= 0;
        else outst <= outst + ((en_i && !busy_o) ? 1 : 0) - (bus_ack_i ? 1 : 0);
    end

    // R6
    limit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outst == int'(MAX_OUT)) |-> busy_o);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= int'(MAX_OUT));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en_o && bus_stall_i) |=> (bus_en_o && $stable(bus_adr_o)
                                       && $stable(bus_we_o) && $stable(bus_wdat_o)));

    // R7
    ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_i |=> valid_o);

    // R7
    idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack_i |=> !valid_o);

    // R8
    we_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> valid_o);

    // R5
    strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en_o |-> ($countones(bus_we_o) != 3));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !we_o && !bus_en_o));
endmodule

bind lsu_top lsu_top_chk #(.MAX_OUT(MAX_OUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .busy_o      (busy_o),
    .valid_o     (valid_o),
    .we_o        (we_o),
    .bus_en_o    (bus_en_o),
    .bus_we_o    (bus_we_o),
    .bus_adr_o   (bus_adr_o),
    .bus_wdat_o  (bus_wdat_o),
    .bus_stall_i (bus_stall_i),
    .bus_ack_i   (bus_ack_i)
);

// File: tb/lsu_top_tb.sv
// Self-checking bench: sweeps all load widths/offsets and store widths/offsets over
// a 16-word memory model with latency 1 or 2 and optional random stalls.
module lsu_top_tb;
    localparam int MAX_OUT = 2;
    localparam int DISP_W  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0, store_i = 1'b0;
    logic [2:0]  funct3_i = '0;
    logic [31:0] base_i = '0, sdata_i = '0;
    logic [DISP_W-1:0] disp_i = '0;
    logic [4:0]  rd_i = '0;
    logic        busy_o, valid_o, we_o, bus_en_o;
    logic [4:0]  rd_o;
    logic [31:0] result_o, bus_adr_o, bus_wdat_o, bus_rdat_i;
    logic [3:0]  bus_we_o;
    logic        bus_stall_i, bus_ack_i;

    always #5 clk = ~clk;

    lsu_top #(.DISP_W(DISP_W), .MAX_OUT(MAX_OUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .store_i(store_i), .funct3_i(funct3_i),
        .base_i(base_i), .sdata_i(sdata_i), .disp_i(disp_i), .rd_i(rd_i),
        .busy_o(busy_o), .valid_o(valid_o), .we_o(we_o), .rd_o(rd_o), .result_o(result_o),
        .bus_en_o(bus_en_o), .bus_we_o(bus_we_o), .bus_adr_o(bus_adr_o),
        .bus_wdat_o(bus_wdat_o), .bus_rdat_i(bus_rdat_i), .bus_stall_i(bus_stall_i),
        .bus_ack_i(bus_ack_i)
    );

    int total = 0, bad = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem [16];
    logic        stall = 1'b0, ack1 = 1'b0, ack2 = 1'b0;
    logic [31:0] d1 = '0, d2 = '0;
    logic [15:0] lfsr = 16'hACE1;
    int          lat = 1;
    bit          stall_en = 1'b0;
    logic        taken;

    assign taken       = bus_en_o && !stall;
    assign bus_stall_i = stall;
    assign bus_ack_i   = (lat == 1) ? ack1 : ack2;
    assign bus_rdat_i  = (lat == 1) ? d1 : d2;

    always @(posedge clk) begin
        lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        stall <= stall_en && lfsr[0] && lfsr[3];
        ack1  <= (taken === 1'b1);
        d1    <= mem[bus_adr_o[5:2]];
        ack2  <= ack1;
        d2    <= d1;
        if (taken === 1'b1)
            for (int i = 0; i < 4; i++)
                if (bus_we_o[i]) mem[bus_adr_o[5:2]][8*i +: 8] <= bus_wdat_o[8*i +: 8];
    end

    // ---------------- expectations ----------------
    typedef struct packed { logic [31:0] adr; logic [3:0] we; logic [31:0] wdat; } bus_e;
    typedef struct packed { logic st; logic [2:0] f3; logic [4:0] rd; logic [31:0] res; } rsp_e;
    bus_e        bq[$];
    rsp_e        rq[$];
    logic [31:0] shadow [16];
    int          dsel = 0;
    int          acc = 0, ackc = 0, max_out = 0;

    function automatic logic [31:0] ld_exp(logic [31:0] w, logic [2:0] f3, logic [1:0] off);
        logic [31:0] b, h;
        b = (w >> (8 * off)) & 32'hFF;
        h = (w >> (8 * off)) & 32'hFFFF;
        case (f3)
            3'b000:  return (b >= 32'h80) ? b + 32'hFFFF_FF00 : b;
            3'b100:  return b;
            3'b001:  return (h >= 32'h8000) ? h + 32'hFFFF_0000 : h;
            3'b101:  return h;
            default: return w;
        endcase
    endfunction

    task automatic issue(bit st, logic [2:0] f3, logic [31:0] addr, logic [31:0] data,
                         logic [4:0] rd);
        logic [DISP_W-1:0] d;
        logic [31:0] dx, strb32, wd, mask;
        logic [3:0]  strb;
        int idx, off;
        case (dsel % 4)
            0: d = 12'h000;
            1: d = 12'h004;
            2: d = 12'hFF0;
            default: d = 12'h7FF;
        endcase
        dsel++;
        dx  = {{(32-DISP_W){d[DISP_W-1]}}, d};
        idx = int'(addr[5:2]);
        off = int'(addr[1:0]);
        if (f3 == 3'b000) begin
            strb = 4'(1 << off);
            wd = (data & 32'hFF) * 32'h0101_0101;
        end else if (f3 == 3'b001) begin
            strb = 4'(3 << off);
            wd = (data & 32'hFFFF) * 32'h0001_0001;
        end else begin
            strb = 4'hF;
            wd = data;
        end
        if (st) begin
            strb32 = 0;
            for (int i = 0; i < 4; i++) if (strb[i]) strb32 = strb32 | (32'hFF << (8*i));
            mask = strb32;
            shadow[idx] = (shadow[idx] & ~mask) | (wd & mask);
            bq.push_back('{adr: addr & ~32'h3, we: strb, wdat: wd});
            rq.push_back('{st: 1'b1, f3: f3, rd: rd, res: 32'h0});
        end else begin
            bq.push_back('{adr: addr & ~32'h3, we: 4'h0, wdat: 32'h0});
            rq.push_back('{st: 1'b0, f3: f3, rd: rd, res: ld_exp(shadow[idx], f3, addr[1:0])});
        end
        @(posedge clk); #1;
        en_i = 1'b1; store_i = st; funct3_i = f3; base_i = addr - dx;
        disp_i = d; sdata_i = data; rd_i = rd;
        while (busy_o) begin @(posedge clk); #1; end
    endtask

    task automatic idle_drain();
        @(posedge clk); #1;
        en_i = 1'b0;
        while (rq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // ---------------- output monitor ----------------
    bus_e be;
    rsp_e re;
    always @(negedge clk) if (rst_n) begin
        if (taken) begin
            if (bq.size() == 0) chk("R1 unexpected bus request", 32'h1, 32'h0);
            else begin
                be = bq.pop_front();
                chk("R1 bus address", bus_adr_o, be.adr);
                chk("R5 strobes", {28'h0, bus_we_o}, {28'h0, be.we});
                if (be.we != 4'h0) chk("R5 write data", bus_wdat_o, be.wdat);
            end
        end
        if (valid_o) begin
            if (rq.size() == 0) chk("R7 unexpected valid", 32'h1, 32'h0);
            else begin
                re = rq.pop_front();
                chk("R7 destination index", {27'h0, rd_o}, {27'h0, re.rd});
                chk("R8 write enable", {31'h0, we_o}, {31'h0, ~re.st});
                if (re.st) chk("R8 store result zero", result_o, 32'h0);
                else if (re.f3 == 3'b000 || re.f3 == 3'b100) chk("R2 byte load", result_o, re.res);
                else if (re.f3 == 3'b001 || re.f3 == 3'b101) chk("R3 half load", result_o, re.res);
                else chk("R4 word load", result_o, re.res);
            end
        end else if (we_o) chk("R8 we without valid", 32'h1, 32'h0);
        if (acc - ackc > max_out) max_out = acc - ackc;
        if (acc - ackc == MAX_OUT) chk("R6 busy at limit", {31'h0, busy_o}, 32'h1);
        if (en_i && !busy_o) acc++;
        if (bus_ack_i) ackc++;
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] pat(int i);
        return (i == 0) ? 32'h705A_8000 : (32'(i) * 32'h9E37_79B9) ^ 32'h80FF_0080;
    endfunction

    task automatic phase(int l, bit s);
        int r;
        lat = l; stall_en = s; r = 0;
        // R11: full sweep under this latency/stall setting
        for (int w = 0; w < 8; w++) issue(1'b1, 3'b010, 32'h2000 + 32'(4*w), pat(w + l), 5'(r++));
        for (int w = 0; w < 8; w++) begin
            for (int o = 0; o < 4; o++) begin
                issue(1'b0, 3'b000, 32'h2000 + 32'(4*w + o), 32'h0, 5'(r++));
                issue(1'b0, 3'b100, 32'h2000 + 32'(4*w + o), 32'h0, 5'(r++));
            end
            for (int o = 0; o < 4; o += 2) begin
                issue(1'b0, 3'b001, 32'h2000 + 32'(4*w + o), 32'h0, 5'(r++));
                issue(1'b0, 3'b101, 32'h2000 + 32'(4*w + o), 32'h0, 5'(r++));
            end
            issue(1'b0, 3'b010, 32'h2000 + 32'(4*w), 32'h0, 5'(r++));
        end
        for (int o = 0; o < 4; o++)
            issue(1'b1, 3'b000, 32'h2020 + 32'(o), 32'hA5A5_A500 | 32'(8'h81 + o + l), 5'(r++));
        issue(1'b1, 3'b001, 32'h2024, 32'hDEAD_F00D + 32'(l), 5'(r++));
        issue(1'b1, 3'b001, 32'h2026, 32'h1234_8765, 5'(r++));
        issue(1'b1, 3'b000, 32'h2029, 32'hFFFF_FF3C + 32'(l), 5'(r++));
        issue(1'b1, 3'b000, 32'h202B, 32'h0000_00C7, 5'(r++));
        for (int w = 8; w < 11; w++) issue(1'b0, 3'b010, 32'h2000 + 32'(4*w), 32'h0, 5'(r++));
        issue(1'b0, 3'b000, 32'h202B, 32'h0, 5'(r++));
        idle_drain();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin mem[i] = '0; shadow[i] = '0; end
        repeat (2) @(negedge clk);
        // R10 reset state
        chk("R10 valid in reset", {31'h0, valid_o}, 32'h0);
        chk("R10 busy in reset", {31'h0, busy_o}, 32'h0);
        chk("R10 bus enable in reset", {31'h0, bus_en_o}, 32'h0);
        chk("R10 we in reset", {31'h0, we_o}, 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        phase(1, 1'b0);
        phase(2, 1'b1);
        phase(1, 1'b1);
        phase(2, 1'b0);
        chk("R7 leftover responses", 32'(rq.size()), 32'h0);
        chk("R1 leftover bus requests", 32'(bq.size()), 32'h0);
        chk("R6 outstanding limit reached", 32'(max_out), 32'(MAX_OUT));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule